// File: doc/BRIEF.md
# Fractional RTC Tick Divider

This block turns a slow reference clock, nominally 32.768 kHz, into a tick whose average rate is 100 Hz. The tick feeds a real-time clock. Each output period lasts either the programmed integer number of reference cycles or one cycle more. A phase accumulator decides which periods are stretched and spreads them evenly through a window of 1000 or 1024 periods. A chosen number of stretched periods per window therefore gives a non-integer average divisor, such as 327.68.

A single 32-bit control word is written and read through a synchronous port. The word holds the fractional count, the integer divisor, the window select, a run enable and a request line that holds the RTC logic in reset. Writing the word always restarts the current period. The tick is a one-cycle pulse in the reference clock domain.

Top module: `rtc_frac_divider`

## Requirements
- R1: After reset the control word reads 0x00051EA8 (integer 327, fraction 680, window 1000, disabled, no reset request), `tick` is 0 and `rtc_rst_req` is 0.
- R2: Control word fields are: fraction in bits [9:0], integer divisor in bits [18:10], window select in bit 19, enable in bit 20 and reset request in bit 21. A write stores bits [21:0], and reading returns them. Bits [31:22] read as zero whatever was written.
- R3: While enabled, every output period lasts INT or INT+1 reference cycles. `tick` is high for exactly the one cycle that follows the clock edge ending a period. Window select 0 means a window of 1000 periods and 1 means 1024. Starting from a write, one full window spans exactly INT×window + FRAC cycles.
- R4: A phase accumulator starts at 0. Each period is stretched exactly when phase+FRAC ≥ window. At the end of a period the phase becomes phase+FRAC, minus the window if that period was stretched.
- R5: A fraction at or above the selected window size acts as equal to the window size, so every period lasts INT+1 cycles.
- R6: While enable is 0, no tick is produced and the divider stays idle. Enabling it starts a fresh period.
- R7: `rtc_rst_req` equals the stored reset-request bit. It changes in the cycle after the write that sets or clears the bit and holds until the next write.
- R8: Any write clears the period counter and the phase accumulator. With the enable bit set, the first tick follows the write edge by the new first-period length.
- R9: A write on the same edge where a period would end takes priority. No tick follows that edge, and the new period starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 32.768 kHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Current control word, bits [31:22] zero |
| tick | output | 1 | One-cycle pulse at the end of each output period |
| rtc_rst_req | output | 1 | Reset request to the RTC logic |

## Verification
The end of a period and a control write can fall on the same clock edge. The write restarts the counter and clears the phase, while the period end emits a tick and advances the phase. The bench provokes the clash by enabling an 8-cycle divisor, waiting seven cycles and then rewriting the word so that the write lands on the eighth edge. It passes when no tick follows that edge and the next tick comes a full eight cycles later. The bench also starts a fresh window from each write and checks every period length against an accumulator model, the stretch count and the window total.

// File: rtl/rfd_pkg.sv
// Package: shared widths, window sizes and control word layout for the
// fractional RTC tick divider. Assumes the 22 used bits of the control word
// sit at the bottom of a 32-bit word.
package rfd_pkg;
    localparam int WORD_W    = 32;
    localparam int FRAC_W    = 10;
    localparam int INT_W     = 9;
    localparam int USED_W    = FRAC_W + INT_W + 3;
    localparam int PH_W      = FRAC_W + 1;
    localparam int LEN_W     = INT_W + 1;
    localparam int WIN_SHORT = 1000;
    localparam int WIN_LONG  = 1024;
    localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0005_1EA8;

    // Packed so that the field order matches the bit layout of the word.
    typedef struct packed {
        logic               rst_req;
        logic               run_en;
        logic               win_sel;
        logic [INT_W-1:0]   int_div;
        logic [FRAC_W-1:0]  frac;
    } ctrl_t;
endpackage

// File: rtl/rfd_ctrl_reg.sv
// Control register: holds the control word, stores the used bits on a write
// and returns them zero-extended on the read port. Assumes a single writer
// with no byte enables.
module rfd_ctrl_reg
    import rfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [WORD_W-1:0] rd_data
);
    ctrl_t ctrl_q;

    // Load the control word on a write; reset to the 100 Hz default.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= ctrl_t'(CTRL_RESET[USED_W-1:0]);
        end else if (wr_en) begin
            ctrl_q <= ctrl_t'(wr_data[USED_W-1:0]);
        end
    end

    // Read path: unused upper bits read as zero.
    always_comb begin
        rd_data = '0;
        rd_data[USED_W-1:0] = ctrl_q;
    end

    assign ctrl = ctrl_q;

    // A write must be visible on the read port one cycle later.
    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {{(WORD_W-USED_W){1'b0}}, $past(wr_data[USED_W-1:0])});
endmodule

// File: rtl/rfd_phase_acc.sv
// Phase accumulator: decides whether the current output period is stretched
// by one cycle and advances the phase at each period end. Assumes the
// fraction is clamped to the window size and the window is 1000 or 1024.
module rfd_phase_acc
    import rfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [FRAC_W-1:0] frac,
    input  logic              win_sel,
    output logic              stretch
);
    localparam logic [PH_W-1:0] WIN_S = PH_W'(WIN_SHORT);
    localparam logic [PH_W-1:0] WIN_L = PH_W'(WIN_LONG);

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] win;
    logic [PH_W-1:0] frac_eff;
    logic [PH_W:0]   sum;
    logic [PH_W-1:0] phase_nxt;

    // Window size, clamped fraction and next phase for this period.
    always_comb begin
        win       = win_sel ? WIN_L : WIN_S;
        frac_eff  = ({1'b0, frac} >= win) ? win : {1'b0, frac};
        sum       = {1'b0, phase_q} + {1'b0, frac_eff};
        stretch   = (sum >= {1'b0, win});
        phase_nxt = stretch ? PH_W'(sum - {1'b0, win}) : PH_W'(sum);
    end

    // Phase register: cleared on a write, stepped at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= phase_nxt;
        end
    end

    // The phase always stays below the window size.
    assert_phase_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < win);
    // A write leaves the accumulator at zero.
    assert_write_clears_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> phase_q == '0);
endmodule

// File: rtl/rfd_period_cnt.sv
// Period counter: counts reference cycles within an output period of INT or
// INT+1 cycles and emits a one-cycle tick after the ending edge. Assumes the
// stretch input is stable within a period (it only changes at period ends).
module rfd_period_cnt
    import rfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [INT_W-1:0] int_div,
    input  logic             stretch,
    output logic             period_end,
    output logic             tick
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len;
    logic [LEN_W-1:0] len_min1;
    logic [LEN_W-1:0] cnt_inc;
    logic             last;
    logic             tick_q;

    // Current period length and end-of-period detection.
    always_comb begin
        len        = {1'b0, int_div} + LEN_W'(stretch);
        len_min1   = (len == '0) ? LEN_W'(1) : len;
        cnt_inc    = cnt_q + LEN_W'(1);
        last       = (cnt_inc >= len);
        period_end = run && !clear && last;
    end

    // Cycle counter: restarts on a write, idles when disabled, wraps at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || !run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc;
        end
    end

    // Tick register: one pulse after each completed period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= period_end;
        end
    end

    assign tick = tick_q;

    // The count never reaches the period length while running.
    assert_cnt_in_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q < len_min1);
    // No tick while the divider is disabled.
    assert_tick_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);
    // A write restarts the period from zero.
    assert_write_clears_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
endmodule

// File: rtl/rtc_frac_divider.sv
// Top: fractional divider producing an average 100 Hz tick from a slow
// reference clock. Combines the control register, phase accumulator and
// period counter. Assumes all logic runs in the reference clock domain.
module rtc_frac_divider
    import rfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              tick,
    output logic              rtc_rst_req
);
    ctrl_t ctrl;
    logic  stretch;
    logic  period_end;

    rfd_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .rd_data (rd_data)
    );

    rfd_phase_acc u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wr_en),
        .advance (period_end),
        .frac    (ctrl.frac),
        .win_sel (ctrl.win_sel),
        .stretch (stretch)
    );

    rfd_period_cnt u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (wr_en),
        .run        (ctrl.run_en),
        .int_div    (ctrl.int_div),
        .stretch    (stretch),
        .period_end (period_end),
        .tick       (tick)
    );

    assign rtc_rst_req = ctrl.rst_req;

    // The reset request follows the written bit one cycle after a write.
    assert_rst_req_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rtc_rst_req == $past(wr_data[USED_W-1]));
    // A write wins over a period end on the same edge.
    assert_write_beats_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tick);
endmodule

// File: tb/rtc_frac_divider_bench.sv
`timescale 1ns/1ps
module rtc_frac_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick;
    logic        rtc_rst_req;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_frac_divider u_rtc_frac_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .tick        (tick),
        .rtc_rst_req (rtc_rst_req)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Called at a negedge; the write is taken at the next posedge.
    task automatic write_reg(input logic [31:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [31:0] cfg(input int iv, input int fr, input bit ws, input bit en);
        return (32'(en) << 20) | (32'(ws) << 19) | (32'(iv) << 10) | 32'(fr);
    endfunction

    // Write an enabled config and check nper periods against the accumulator model.
    task automatic run_periods(input int iv, input int fr, input bit ws, input int nper, input bit full);
        int win, fe, phase, k, nstr, lenp;
        bit s;
        win = ws ? 1024 : 1000;
        fe = (fr >= win) ? win : fr;
        phase = 0; k = 0; nstr = 0;
        write_reg(cfg(iv, fr, ws, 1'b1));
        chk(tick == 1'b0, "R9 no tick on write edge", tick, 0);
        for (int p = 0; p < nper; p++) begin
            s = (phase + fe >= win);
            lenp = iv + (s ? 1 : 0);
            phase = s ? phase + fe - win : phase + fe;
            if (s) nstr++;
            for (int c = 1; c <= lenp; c++) begin
                @(negedge clk);
                k++;
                if (c < lenp) begin
                    if (tick) chk(1'b0, "R4 early tick", k, 0);
                end else begin
                    chk(tick == 1'b1, "R3/R4 tick at period end", tick, 1);
                end
            end
        end
        @(negedge clk);
        k++;
        if (lenp > 1) chk(tick == 1'b0, "R3 tick one cycle wide", tick, 0);
        if (full) begin
            chk(k - 1 == iv * win + fe, "R3 window length", k - 1, iv * win + fe);
            chk(nstr == fe, "R5 stretched period count", nstr, fe);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rd_data == 32'h0005_1EA8, "R1 reset word", rd_data, 32'h0005_1EA8);
        chk(tick == 1'b0, "R1 tick in reset", tick, 0);
        chk(rtc_rst_req == 1'b0, "R1 reset request in reset", rtc_rst_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: default config is disabled, no ticks
        begin
            int seen = 0;
            for (int i = 0; i < 700; i++) begin
                @(negedge clk);
                if (tick) seen++;
            end
            chk(seen == 0, "R6 no ticks while disabled (default)", seen, 0);
        end

        // R2: readback with upper bits ignored
        write_reg(32'hFFC0_0000 | 32'h000A_1234);
        chk(rd_data == 32'h000A_1234, "R2 readback upper bits zero", rd_data, 32'h000A_1234);
        chk(rtc_rst_req == 1'b0, "R7 request clear", rtc_rst_req, 0);

        // R7: reset request line
        write_reg(32'h0020_0000);
        chk(rtc_rst_req == 1'b1, "R7 request set", rtc_rst_req, 1);
        repeat (20) @(negedge clk);
        chk(rtc_rst_req == 1'b1, "R7 request held", rtc_rst_req, 1);
        write_reg(32'h0000_0000);
        chk(rtc_rst_req == 1'b0, "R7 request released", rtc_rst_req, 0);

        // R3/R4: default divisor, first periods 327 then 328
        run_periods(327, 680, 1'b0, 2, 1'b0);

        // R3/R4/R5: full windows over a sweep of fractions and both window sizes
        run_periods(3, 0,    1'b0, 1000, 1'b1);
        run_periods(3, 1,    1'b0, 1000, 1'b1);
        run_periods(3, 680,  1'b0, 1000, 1'b1);
        run_periods(3, 999,  1'b0, 1000, 1'b1);
        run_periods(3, 1000, 1'b0, 1000, 1'b1);
        run_periods(3, 1023, 1'b0, 1000, 1'b1);
        run_periods(3, 0,    1'b1, 1024, 1'b1);
        run_periods(3, 512,  1'b1, 1024, 1'b1);
        run_periods(2, 300,  1'b1, 1024, 1'b1);
        run_periods(3, 1023, 1'b1, 1024, 1'b1);

        // R6: disabling stops ticks
        write_reg(cfg(3, 0, 1'b0, 1'b0));
        begin
            int seen = 0;
            for (int i = 0; i < 500; i++) begin
                @(negedge clk);
                if (tick) seen++;
            end
            chk(seen == 0, "R6 no ticks after disable", seen, 0);
        end

        // R8: rewrite mid-period restarts the count
        write_reg(cfg(10, 0, 1'b0, 1'b1));
        repeat (5) @(negedge clk);
        run_periods(10, 0, 1'b0, 2, 1'b0);

        // R9: write on the period-ending edge suppresses that tick
        write_reg(cfg(8, 0, 1'b0, 1'b1));
        repeat (7) @(negedge clk);
        run_periods(8, 0, 1'b0, 2, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end
endmodule